// File: doc/BRIEF.md
# Atomic Set/Clear Flag Register Bank

This block keeps a bank of flag bits behind a small synchronous register bus. Software never modifies a flag through read-modify-write. Instead it writes a mask to a set address or to a clear address, and only the flags whose mask bit is 1 change. Several software agents can therefore each own a subset of the bits and update them with a single write, without racing one another. Reading is done through a separate read-only view of the flags.

Hardware can also raise or drop flags through per-bit set and clear inputs. These act in the same cycle as any software write, under a fixed priority. The current flag vector is driven on an output for use by neighbouring logic. Reads return data one cycle after the read request, through a registered read-data port.

Top module: `atomic_flag_bank`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears every flag and the read-data register to 0x00.
- R2: A write to offset 0x1 sets every flag whose data bit is 1. Data bit i maps to flag i, so writing 0x04 sets only flag bit 2.
- R3: A write to offset 0x2 clears every flag whose data bit is 1. Data bit i maps to flag i.
- R4: In a write to offset 0x1 or 0x2, a data bit of 0 leaves the matching flag unchanged.
- R5: A read of offset 0x0 returns the flag vector. A write to offset 0x0 changes nothing.
- R6: Reads of offsets 0x1, 0x2 and of any unmapped offset (0x3 and up) return 0x00. Writes to unmapped offsets change nothing.
- R7: A write takes effect at the next rising edge. `bus_rdata` is loaded at the rising edge that samples a read request, so a read issued in the cycle after a write returns the updated flags. `bus_rdata` holds its value in cycles without a read.
- R8: In any cycle, bit i of `hw_set` sets flag i and bit i of `hw_clr` clears flag i, at the next rising edge.
- R9: For each bit, when requests collide in one cycle, the priority from highest to lowest is: hardware clear, hardware set, software clear, software set.
- R10: `flags_o` always shows the current flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Bus access request for this cycle |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W (4) | Register offset |
| bus_wdata | input | FLAG_W (8) | Write data / bit mask |
| bus_rdata | output | FLAG_W (8) | Registered read data, valid one cycle after the read |
| hw_set | input | FLAG_W (8) | Per-bit hardware set requests |
| hw_clr | input | FLAG_W (8) | Per-bit hardware clear requests |
| flags_o | output | FLAG_W (8) | Current flag vector |

## Verification
The assertions check several properties on every clock, for every bit. A hardware clear always leaves the flag at 0, and an uncontested hardware set leaves it at 1. A decoded software clear or set lands unless a higher-priority request overrides it. A bit with no request keeps its value, and the read-data register stays put between reads. Some behaviour can only be shown by the bench's scenarios, because it spans the whole bus path: the address map itself, including writes to the read-only and unmapped offsets being ignored, the zero returned by reads of write-only offsets, and the exact cycle in which a read sees an earlier write. The bench also runs long random mixes of bus and hardware traffic against a reference model.

// File: rtl/flagbank_pkg.sv
// Package: shared offsets and read-select type for the flag register bank.
// Assumes: offsets fit in the address width chosen by the top level.
package flagbank_pkg;
    localparam int unsigned FB_OFS_VIEW = 0;   // read-only flag view
    localparam int unsigned FB_OFS_SET  = 1;   // write-only set mask
    localparam int unsigned FB_OFS_CLR  = 2;   // write-only clear mask

    typedef enum logic {
        FB_RSEL_ZERO = 1'b0,
        FB_RSEL_VIEW = 1'b1
    } fb_rsel_e;
endpackage

// File: rtl/flagbank_decode.sv
// Module: flagbank_decode
// Turns one bus access into per-bit software set/clear masks and a read
// strobe with its data select. Purely combinational.
// Assumes: at most one access per cycle; bus_wdata is only meaningful on writes.
module flagbank_decode
    import flagbank_pkg::*;
#(
    parameter int unsigned FLAG_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [FLAG_W-1:0] wdata_i,
    output logic [FLAG_W-1:0] sw_set_o,
    output logic [FLAG_W-1:0] sw_clr_o,
    output logic              rd_en_o,
    output fb_rsel_e          rsel_o
);
    localparam logic [ADDR_W-1:0] OFS_VIEW = ADDR_W'(FB_OFS_VIEW);
    localparam logic [ADDR_W-1:0] OFS_SET  = ADDR_W'(FB_OFS_SET);
    localparam logic [ADDR_W-1:0] OFS_CLR  = ADDR_W'(FB_OFS_CLR);

    logic wr_access;
    logic rd_access;

    // Split the access into read and write qualifiers.
    always_comb begin
        wr_access = valid_i &&  write_i;
        rd_access = valid_i && !write_i;
    end

    // Route write data to the set or clear mask by offset; others drop it.
    always_comb begin
        sw_set_o = '0;
        sw_clr_o = '0;
        if (wr_access) begin
            if (addr_i == OFS_SET) sw_set_o = wdata_i;
            if (addr_i == OFS_CLR) sw_clr_o = wdata_i;
        end
    end

    // Pick read source: only the view offset returns flags.
    always_comb begin
        rd_en_o = rd_access;
        rsel_o  = (addr_i == OFS_VIEW) ? FB_RSEL_VIEW : FB_RSEL_ZERO;
    end
endmodule

// File: rtl/flagbank_core.sv
// Module: flagbank_core
// Holds the flag register. Each bit resolves its own requests with the
// fixed order hw clear > hw set > sw clear > sw set.
// Assumes: synchronous active-low reset; all requests are single-cycle levels.
module flagbank_core #(
    parameter int unsigned FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] sw_set_i,
    input  logic [FLAG_W-1:0] sw_clr_i,
    input  logic [FLAG_W-1:0] hw_set_i,
    input  logic [FLAG_W-1:0] hw_clr_i,
    output logic [FLAG_W-1:0] flags_q
);
    for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
        // Update one flag bit according to the fixed priority.
        always_ff @(posedge clk) begin
            if (!rst_n)            flags_q[b] <= 1'b0;
            else if (hw_clr_i[b])  flags_q[b] <= 1'b0;
            else if (hw_set_i[b])  flags_q[b] <= 1'b1;
            else if (sw_clr_i[b])  flags_q[b] <= 1'b0;
            else if (sw_set_i[b])  flags_q[b] <= 1'b1;
        end

        // R9: hardware clear beats every other request.
        a_r9_hwclr_wins : assert property (@(posedge clk) disable iff (!rst_n)
            hw_clr_i[b] |=> !flags_q[b]);
        // R9: hardware set beats both software requests.
        a_r9_hwset_beats_sw : assert property (@(posedge clk) disable iff (!rst_n)
            (hw_set_i[b] && !hw_clr_i[b]) |=> flags_q[b]);
        // R3: software clear lands unless hardware sets.
        a_r3_sw_clear : assert property (@(posedge clk) disable iff (!rst_n)
            (sw_clr_i[b] && !hw_set_i[b]) |=> !flags_q[b]);
        // R2: software set lands when nothing stronger is requested.
        a_r2_sw_set : assert property (@(posedge clk) disable iff (!rst_n)
            (sw_set_i[b] && !sw_clr_i[b] && !hw_clr_i[b]) |=> flags_q[b]);
        // R4: a bit with no request keeps its value.
        a_r4_idle_hold : assert property (@(posedge clk) disable iff (!rst_n)
            !(sw_set_i[b] || sw_clr_i[b] || hw_set_i[b] || hw_clr_i[b])
            |=> $stable(flags_q[b]));
    end

    // R1: reset leaves every flag at zero.
    a_r1_reset_clear : assert property (@(posedge clk)
        !rst_n |=> (flags_q == '0));
endmodule

// File: rtl/flagbank_rdmux.sv
// Module: flagbank_rdmux
// Registers read data: on a read strobe, loads flags or zero per the select;
// otherwise holds. Gives one cycle of read latency.
// Assumes: synchronous active-low reset.
module flagbank_rdmux
    import flagbank_pkg::*;
#(
    parameter int unsigned FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  fb_rsel_e          rsel_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [FLAG_W-1:0] rdata_q
);
    logic [FLAG_W-1:0] rd_next;

    // Choose the value a read would return.
    always_comb begin
        rd_next = (rsel_i == FB_RSEL_VIEW) ? flags_i : '0;
    end

    // Capture read data on a read strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rd_next;
    end

    // R7: read data holds in cycles without a read.
    a_r7_rdata_hold : assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_q));
    // R6: reads of non-view offsets return zero.
    a_r6_zero_read : assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rsel_i == FB_RSEL_ZERO) |=> (rdata_q == '0));
endmodule

// File: rtl/atomic_flag_bank.sv
// Module: atomic_flag_bank (top)
// Flag register bank with a read-only view and write-only set/clear masks,
// plus per-bit hardware set/clear inputs.
// Assumes: one bus access per cycle; synchronous active-low reset.
module atomic_flag_bank
    import flagbank_pkg::*;
#(
    parameter int unsigned FLAG_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [FLAG_W-1:0] bus_wdata,
    output logic [FLAG_W-1:0] bus_rdata,
    input  logic [FLAG_W-1:0] hw_set,
    input  logic [FLAG_W-1:0] hw_clr,
    output logic [FLAG_W-1:0] flags_o
);
    logic [FLAG_W-1:0] sw_set;
    logic [FLAG_W-1:0] sw_clr;
    logic              rd_en;
    fb_rsel_e          rsel;
    logic [FLAG_W-1:0] flags;

    flagbank_decode #(.FLAG_W(FLAG_W), .ADDR_W(ADDR_W)) u_decode (
        .valid_i  (bus_valid),
        .write_i  (bus_write),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .sw_set_o (sw_set),
        .sw_clr_o (sw_clr),
        .rd_en_o  (rd_en),
        .rsel_o   (rsel)
    );

    flagbank_core #(.FLAG_W(FLAG_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_set_i (sw_set),
        .sw_clr_i (sw_clr),
        .hw_set_i (hw_set),
        .hw_clr_i (hw_clr),
        .flags_q  (flags)
    );

    flagbank_rdmux #(.FLAG_W(FLAG_W)) u_rdmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en_i (rd_en),
        .rsel_i  (rsel),
        .flags_i (flags),
        .rdata_q (bus_rdata)
    );

    // Drive the flag vector out to neighbouring logic.
    always_comb flags_o = flags;

    // R10: the output follows the register after a hardware clear.
    a_r10_out_follows : assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr != '0) |=> ((flags_o & $past(hw_clr)) == '0));
endmodule

// File: tb/tb_atomic_flag_bank.sv
// Scoreboard bench: the driver task predicts each read and queues it;
// a monitor pops and compares when read data appears.
module tb_atomic_flag_bank;
    localparam int FW = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [FW-1:0] bus_wdata = '0;
    logic [FW-1:0] bus_rdata;
    logic [FW-1:0] hw_set = '0;
    logic [FW-1:0] hw_clr = '0;
    logic [FW-1:0] flags_o;

    int checks = 0;
    int fails  = 0;
    logic [FW-1:0] model = '0;
    logic [FW-1:0] exp_q[$];
    string         tag_q[$];
    logic          rd_seen = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    atomic_flag_bank #(.FLAG_W(FW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_set(hw_set), .hw_clr(hw_clr), .flags_o(flags_o)
    );

    task automatic check(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, predict a read, advance the model.
    task automatic step(input logic v, input logic we, input logic [AW-1:0] a,
                        input logic [FW-1:0] d, input logic [FW-1:0] hs,
                        input logic [FW-1:0] hc, input string tag);
        logic [FW-1:0] sws, swc;
        @(negedge clk);
        check("R10 flags_o", flags_o, model);
        bus_valid = v; bus_write = we; bus_addr = a; bus_wdata = d;
        hw_set = hs; hw_clr = hc;
        if (v && !we) begin
            exp_q.push_back((a == 0) ? model : '0);
            tag_q.push_back(tag);
        end
        sws = (v && we && a == 1) ? d : '0;
        swc = (v && we && a == 2) ? d : '0;
        model = ((((model | sws) & ~swc) | hs) & ~hc);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, '0, '0, '0, '0, "idle");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_valid = 1'b0; hw_set = '0; hw_clr = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model = '0;
        check("R1 flags after reset", flags_o, 8'h00);
        check("R1 rdata after reset", bus_rdata, 8'h00);
    endtask

    // Monitor: note reads at the edge, compare at the following falling edge.
    always @(posedge clk) rd_seen <= rst_n && bus_valid && !bus_write;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R7: unexpected read data 0x%02h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R2: set a single bit, then read it back next cycle (R7 latency)
        step(1, 1, 4'h1, 8'h04, '0, '0, "R2 set");
        step(1, 0, 4'h0, '0, '0, '0, "R2 set 0x04 only bit 2");
        // R4: zero bits untouched
        step(1, 1, 4'h1, 8'hA0, '0, '0, "R4 set");
        step(1, 0, 4'h0, '0, '0, '0, "R4 other bits kept");
        // R3: clear
        step(1, 1, 4'h2, 8'h04, '0, '0, "R3 clr");
        step(1, 0, 4'h0, '0, '0, '0, "R3 clear bit 2");
        // R5: write to view ignored
        step(1, 1, 4'h0, 8'hFF, '0, '0, "R5 wr view");
        step(1, 0, 4'h0, '0, '0, '0, "R5 view write ignored");
        // R6: write-only and unmapped offsets
        step(1, 0, 4'h1, '0, '0, '0, "R6 read set offset");
        step(1, 0, 4'h2, '0, '0, '0, "R6 read clear offset");
        step(1, 0, 4'hF, '0, '0, '0, "R6 read unmapped");
        step(1, 1, 4'h7, 8'hFF, '0, '0, "R6 wr unmapped");
        step(1, 1, 4'h3, 8'h5F, '0, '0, "R6 wr unmapped");
        step(1, 0, 4'h0, '0, '0, '0, "R6 unmapped write ignored");
        // R7: rdata holds between reads
        step(1, 1, 4'h1, 8'h01, '0, '0, "R7 set");
        idle();
        @(negedge clk);
        check("R7 rdata hold", bus_rdata, 8'hA0);
        step(1, 0, 4'h0, '0, '0, '0, "R7 read after write");
        // R8: hardware set and clear
        step(0, 0, '0, '0, 8'h10, 8'h80, "R8 hw");
        step(1, 0, 4'h0, '0, '0, '0, "R8 hw set/clear");
        // R9: collisions
        step(1, 1, 4'h1, 8'h02, 8'h02, 8'h02, "R9 hwclr>hwset>swset");
        step(1, 0, 4'h0, '0, '0, '0, "R9 hw clear wins");
        step(1, 1, 4'h2, 8'h08, 8'h08, '0, "R9 hwset>swclr");
        step(1, 0, 4'h0, '0, '0, '0, "R9 hw set beats sw clear");
        step(1, 1, 4'h1, 8'h40, '0, 8'h40, "R9 hwclr>swset");
        step(1, 0, 4'h0, '0, '0, '0, "R9 hw clear beats sw set");
        step(1, 1, 4'h2, 8'h01, '0, 8'h00, "R9 swclr");
        step(1, 0, 4'h0, '0, '0, '0, "R9 sw clear alone");
        // Random mix of bus and hardware traffic (R8, R9)
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] a;
            a = AW'($urandom_range(0, 4));
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a,
                 FW'($urandom), FW'($urandom) & FW'($urandom),
                 FW'($urandom) & FW'($urandom), "R9 random mix");
        end
        step(1, 0, 4'h0, '0, '0, '0, "R9 random final");
        // R1: reset mid-run
        step(1, 1, 4'h1, 8'hFF, '0, '0, "R1 fill");
        step(1, 0, 4'h0, '0, '0, '0, "R1 filled");
        do_reset();
        step(1, 0, 4'h0, '0, '0, '0, "R1 read after reset");
        idle();
        idle();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule